// File: doc/BRIEF.md
# Sideband Message Bus Bridge

This block lets a host reach a single-master sideband message bus through three registers: a command word, an upper-address register and a data word. Software first loads the data word (for writes) and, if the target register lies above the first 256 locations, the upper-address register. It then writes the command word. That one write sends a single request to the chosen target port, carrying the opcode, the port, the full 32-bit register address, the byte enables and the data.

The bridge holds a busy state until the target answers. When the opcode is the read code, the answer is captured into the data word, and the host reads it from there. Any other opcode, such as a doorbell, travels to the target unchanged. For such opcodes the data word is left as it was.

The upper-address register clears itself at every launch, so a plain low-address access never needs a separate clearing write. A command written while a transfer is still open is dropped, and a sticky error flag records it. A host read of the data word during a transfer waits, with ready low, until the answer has been captured.

Top module: `sb_bridge`

## Requirements
- R1: After reset, busy, err and req_valid are 0, and reads of the control (sel 0), extended (sel 1), data (sel 2) and status (sel 3) registers all return 0.
- R2: A control write while idle raises req_valid on the next cycle and sends exactly one request. In that request, opcode = word[31:24], port = word[23:16], byte enables = word[3:0], and address = {extended[31:8], word[15:8]}.
- R3: A write to the extended register keeps bits [31:8], and a read of that register returns them with bits [7:0] as zero. The register reads 0 again once a control write has launched a transfer.
- R4: Writes to the data or extended registers never start a request.
- R5: For every opcode other than 8'h10, the request data is the data-register value at the launching control write. A data write made later, while busy, does not change what is sent.
- R6: With opcode 8'h10 (read), the response data is placed in the data register. With any other opcode (8'h11 write, 8'hE0 doorbell or others), the data register keeps its value.
- R7: busy is 1 from the cycle after launch until the cycle after the response is accepted. req_valid and the request fields stay stable until req_ready is seen.
- R8: A host read of the data register while busy keeps host_ready low until the response is captured, and then returns the captured response.
- R9: A control write while busy starts no request and leaves the control register unchanged. It sets err, which stays 1 until reset.
- R10: The status register (sel 2'd3) reads {30'b0, err, busy}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host access request |
| host_write | input | 1 | 1 = write, 0 = read |
| host_sel | input | 2 | Register select: 0 control, 1 extended, 2 data, 3 status |
| host_wdata | input | 32 | Host write data |
| host_ready | output | 1 | Access completes when high together with host_valid |
| host_rdata | output | 32 | Read data, valid while host_ready is high |
| req_valid | output | 1 | Sideband request valid |
| req_ready | input | 1 | Target accepts the request |
| req_opcode | output | 8 | Request opcode |
| req_port | output | 8 | Target port |
| req_addr | output | 32 | Full target register address |
| req_be | output | 4 | Byte enables, 4'hF = full word |
| req_data | output | 32 | Request data |
| rsp_valid | input | 1 | Target response strobe |
| rsp_data | input | 32 | Target response data |
| busy | output | 1 | Transfer in flight |
| err | output | 1 | Sticky: command written while busy |

## Verification
A bad launch state shows up within one cycle. Either req_valid fails to rise after the control write, or a second request appears during a transfer. A stale upper-address value is visible on req_addr of the very next request and in the extended-register readback. A wrong capture choice shows up in the data-register read right after the transfer closes: the register holds a response after a non-read opcode, or an old value after a read. A busy flag that clears early lets a stalled data read finish with pre-response data.

// File: rtl/sbb_pkg.sv
package sbb_pkg;
    localparam int SB_DW    = 32;
    localparam int OP_W     = 8;
    localparam int PORT_W   = 8;
    localparam int BE_W     = 4;
    localparam int LO_W     = 8;
    localparam int HI_W     = SB_DW - LO_W;
    localparam int OP_LSB   = SB_DW - OP_W;
    localparam int PORT_LSB = OP_LSB - PORT_W;
    localparam int LO_LSB   = PORT_LSB - LO_W;

    localparam logic [OP_W-1:0] OP_RD = 8'h10;
    localparam logic [OP_W-1:0] OP_WR = 8'h11;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_EXT  = 2'd1,
        SEL_DATA = 2'd2,
        SEL_STAT = 2'd3
    } sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2
    } st_e;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [PORT_W-1:0] port;
        logic [SB_DW-1:0]  addr;
        logic [BE_W-1:0]   be;
        logic [SB_DW-1:0]  data;
    } sb_req_t;

    function automatic logic is_read(input logic [OP_W-1:0] op);
        return op == OP_RD;
    endfunction

    function automatic sb_req_t decode_cmd(input logic [SB_DW-1:0] cmd,
                                           input logic [HI_W-1:0]  hi,
                                           input logic [SB_DW-1:0] data);
        sb_req_t r;
        r.op   = cmd[OP_LSB +: OP_W];
        r.port = cmd[PORT_LSB +: PORT_W];
        r.addr = {hi, cmd[LO_LSB +: LO_W]};
        r.be   = cmd[BE_W-1:0];
        r.data = data;
        return r;
    endfunction
endpackage

// File: rtl/sbb_regs.sv
module sbb_regs
    import sbb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             host_valid,
    input  logic             host_write,
    input  logic [1:0]       host_sel,
    input  logic [SB_DW-1:0] host_wdata,
    output logic             host_ready,
    output logic [SB_DW-1:0] host_rdata,
    input  logic             busy,
    input  logic             cap_valid,
    input  logic [SB_DW-1:0] cap_data,
    output logic             go,
    output sb_req_t          go_req,
    output logic             err
);
    logic [SB_DW-1:0] ctrl_q;
    logic [HI_W-1:0]  ext_q;
    logic [SB_DW-1:0] data_q;
    logic             err_q;
    sel_e             sel;
    logic             wr, ctrl_wr;

    assign sel     = sel_e'(host_sel);
    assign wr      = host_valid && host_write;
    assign ctrl_wr = wr && (sel == SEL_CTRL);
    assign go      = ctrl_wr && !busy;
    assign go_req  = decode_cmd(host_wdata, ext_q, data_q);
    assign err     = err_q;

    // Data reads stall while a transfer is open
    assign host_ready = !(host_valid && !host_write && (sel == SEL_DATA) && busy);

    always_comb begin
        unique case (sel)
            SEL_CTRL: host_rdata = ctrl_q;
            SEL_EXT:  host_rdata = {ext_q, {LO_W{1'b0}}};
            SEL_DATA: host_rdata = data_q;
            default:  host_rdata = {{(SB_DW-2){1'b0}}, err_q, busy};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            ext_q  <= '0;
            data_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (go)
                ctrl_q <= host_wdata;
            if (go)
                ext_q <= '0;
            else if (wr && sel == SEL_EXT)
                ext_q <= host_wdata[SB_DW-1:LO_W];
            if (cap_valid)
                data_q <= cap_data;
            else if (wr && sel == SEL_DATA)
                data_q <= host_wdata;
            if (ctrl_wr && busy)
                err_q <= 1'b1;
        end
    end
endmodule

// File: rtl/sbb_launch.sv
module sbb_launch
    import sbb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  sb_req_t          go_req,
    output sb_req_t          req,
    output logic             req_valid,
    input  logic             req_ready,
    input  logic             rsp_valid,
    input  logic [SB_DW-1:0] rsp_data,
    output logic             busy,
    output logic             cap_valid,
    output logic [SB_DW-1:0] cap_data
);
    st_e     st;
    sb_req_t req_q;

    assign req       = req_q;
    assign req_valid = (st == ST_SEND);
    assign busy      = (st != ST_IDLE);
    assign cap_valid = (st == ST_WAIT) && rsp_valid && is_read(req_q.op);
    assign cap_data  = rsp_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            req_q <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (go) begin
                    req_q <= go_req;
                    st    <= ST_SEND;
                end
                ST_SEND: if (req_ready) st <= ST_WAIT;
                ST_WAIT: if (rsp_valid) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sb_bridge.sv
module sb_bridge
    import sbb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_valid,
    input  logic              host_write,
    input  logic [1:0]        host_sel,
    input  logic [SB_DW-1:0]  host_wdata,
    output logic              host_ready,
    output logic [SB_DW-1:0]  host_rdata,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [OP_W-1:0]   req_opcode,
    output logic [PORT_W-1:0] req_port,
    output logic [SB_DW-1:0]  req_addr,
    output logic [BE_W-1:0]   req_be,
    output logic [SB_DW-1:0]  req_data,
    input  logic              rsp_valid,
    input  logic [SB_DW-1:0]  rsp_data,
    output logic              busy,
    output logic              err
);
    logic             go, cap_valid;
    logic [SB_DW-1:0] cap_data;
    sb_req_t          go_req, req;

    sbb_regs u_regs (
        .clk(clk), .rst(rst),
        .host_valid(host_valid), .host_write(host_write), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_ready(host_ready), .host_rdata(host_rdata),
        .busy(busy), .cap_valid(cap_valid), .cap_data(cap_data),
        .go(go), .go_req(go_req), .err(err)
    );

    sbb_launch u_launch (
        .clk(clk), .rst(rst), .go(go), .go_req(go_req),
        .req(req), .req_valid(req_valid), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .busy(busy), .cap_valid(cap_valid), .cap_data(cap_data)
    );

    assign req_opcode = req.op;
    assign req_port   = req.port;
    assign req_addr   = req.addr;
    assign req_be     = req.be;
    assign req_data   = req.data;
endmodule

// File: rtl/sbb_checker.sv
module sbb_checker
    import sbb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              host_valid,
    input logic              host_write,
    input logic [1:0]        host_sel,
    input logic              host_ready,
    input logic              req_valid,
    input logic              req_ready,
    input logic [OP_W-1:0]   req_opcode,
    input logic [PORT_W-1:0] req_port,
    input logic [SB_DW-1:0]  req_addr,
    input logic [SB_DW-1:0]  req_data,
    input logic              busy,
    input logic              err
);
    logic ctrl_wr, data_rd;
    assign ctrl_wr = host_valid && host_write && host_sel == 2'd0;
    assign data_rd = host_valid && !host_write && host_sel == 2'd2;

    p_launch_r2: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr && !busy |=> req_valid && busy);

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_addr)
            && $stable(req_opcode) && $stable(req_port) && $stable(req_data));

    p_valid_busy_r7: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> busy);

    p_stall_r8: assert property (@(posedge clk) disable iff (rst)
        data_rd && busy |-> !host_ready);

    p_no_relaunch_r9: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr && busy |=> !$rose(req_valid));

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    p_err_cause_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> $past(ctrl_wr && busy));
endmodule

bind sb_bridge sbb_checker u_chk (.*);

// File: tb/tb_sb_bridge.sv
`timescale 1ns/1ps
module tb_sb_bridge;
    logic        clk = 0;
    logic        rst = 1;
    logic        host_valid = 0, host_write = 0;
    logic [1:0]  host_sel = 0;
    logic [31:0] host_wdata = 0;
    logic        host_ready;
    logic [31:0] host_rdata;
    logic        req_valid, req_ready = 0;
    logic [7:0]  req_opcode, req_port;
    logic [31:0] req_addr, req_data;
    logic [3:0]  req_be;
    logic        rsp_valid = 0;
    logic [31:0] rsp_data = 0;
    logic        busy, err;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sb_bridge dut (.*);

    // target model state
    int          n_req = 0;
    bit          pending = 0;
    int          dly = 0;
    int          rsp_dly = 0;
    bit          hold_ready = 0;
    logic [7:0]  cap_op, cap_port;
    logic [31:0] cap_addr, cap_data;
    logic [3:0]  cap_be;

    function automatic logic [31:0] resp_of(logic [31:0] a, logic [7:0] p);
        return (a * 32'h9E3779B1) ^ {p, 24'h00A5C3};
    endfunction

    function automatic logic [31:0] cmd_of(logic [7:0] op, logic [7:0] p,
                                           logic [7:0] lo, logic [3:0] be);
        return {op, p, lo, 4'h0, be};
    endfunction

    initial begin
        forever begin
            @(negedge clk);
            rsp_valid = 0;
            req_ready = 0;
            if (pending) begin
                if (dly == 0) begin
                    rsp_valid = 1;
                    rsp_data  = resp_of(cap_addr, cap_port);
                    pending   = 0;
                end else dly--;
            end else if (req_valid && !hold_ready && ($urandom % 3 != 0)) begin
                req_ready = 1;
                cap_op = req_opcode; cap_port = req_port; cap_addr = req_addr;
                cap_be = req_be; cap_data = req_data;
                n_req++; pending = 1; dly = rsp_dly;
            end
        end
    end

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_wr(logic [1:0] s, logic [31:0] d);
        @(negedge clk);
        host_valid = 1; host_write = 1; host_sel = s; host_wdata = d;
        @(posedge clk); #1;
        host_valid = 0; host_write = 0;
    endtask

    task automatic host_rd(logic [1:0] s, output logic [31:0] d, output int stalls);
        stalls = 0;
        @(negedge clk);
        host_valid = 1; host_write = 0; host_sel = s;
        forever begin
            #2;
            if (host_ready) begin
                d = host_rdata;
                @(posedge clk); #1;
                host_valid = 0;
                break;
            end
            stalls++;
            @(negedge clk);
        end
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy);
    endtask

    task automatic do_txn(logic [7:0] op, logic [7:0] p, logic [31:0] a,
                          logic [3:0] be, logic [31:0] wd);
        logic [31:0] v, exp;
        int st, n0;
        bit rd;
        rd = (op == 8'h10);
        host_wr(2'd2, wd);
        if (a[31:8] != 0) host_wr(2'd1, a);
        n0 = n_req;
        host_wr(2'd0, cmd_of(op, p, a[7:0], be));
        check(busy === 1'b1, "R7 busy after launch", {31'b0, busy}, 1);
        check(req_valid === 1'b1, "R2 req_valid after launch", {31'b0, req_valid}, 1);
        wait_idle();
        check(n_req == n0 + 1, "R2 one request", n_req, n0 + 1);
        check(cap_op == op && cap_port == p && cap_be == be, "R2 op/port/be",
              {cap_op, cap_port, 12'h0, cap_be}, {op, p, 12'h0, be});
        check(cap_addr == a, "R2 address", cap_addr, a);
        if (!rd) check(cap_data == wd, "R5 sent data", cap_data, wd);
        host_rd(2'd2, v, st);
        exp = rd ? resp_of(a, p) : wd;
        check(v == exp, rd ? "R6 read capture" : "R6 data kept", v, exp);
        host_rd(2'd1, v, st);
        check(v == 0, "R3 ext self-clear", v, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int st, n0;
        void'($urandom(32'd1234));
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1 reset state
        check(busy === 0 && err === 0 && req_valid === 0, "R1 flags",
              {29'b0, busy, err, req_valid}, 0);
        for (int s = 0; s < 4; s++) begin
            host_rd(s[1:0], v, st);
            check(v == 0, "R1 register reads", v, 0);
        end

        // R3/R4 loads without launch
        n0 = n_req;
        host_wr(2'd1, 32'hABCDEF12);
        host_rd(2'd1, v, st);
        check(v == 32'hABCDEF00, "R3 ext readback", v, 32'hABCDEF00);
        host_wr(2'd2, 32'h13572468);
        repeat (4) @(negedge clk);
        check(n_req == n0 && req_valid === 0 && busy === 0, "R4 no launch", n_req, n0);
        host_rd(2'd2, v, st);
        check(v == 32'h13572468, "R4 data readback", v, 32'h13572468);

        // directed transfers: write with ext, read low-only, doorbell
        rsp_dly = 2;
        do_txn(8'h11, 8'h04, 32'h00123407, 4'hF, 32'hCAFEF00D);
        host_rd(2'd0, v, st);
        check(v == cmd_of(8'h11, 8'h04, 8'h07, 4'hF), "R2 ctrl readback", v,
              cmd_of(8'h11, 8'h04, 8'h07, 4'hF));
        do_txn(8'h10, 8'h04, 32'h0000000E, 4'hF, 32'h11111111);
        do_txn(8'hE0, 8'h04, 32'h00000000, 4'hF, 32'h0BADBEEF);

        // R5: later data write while busy does not change the sent data
        hold_ready = 1;
        host_wr(2'd2, 32'hAAAA5555);
        host_wr(2'd0, cmd_of(8'h11, 8'h21, 8'h30, 4'h3));
        host_wr(2'd2, 32'h5555AAAA);
        repeat (3) @(negedge clk);
        check(req_data == 32'hAAAA5555, "R7 held request data", req_data, 32'hAAAA5555);
        hold_ready = 0;
        wait_idle();
        check(cap_data == 32'hAAAA5555, "R5 launch value sent", cap_data, 32'hAAAA5555);
        host_rd(2'd2, v, st);
        check(v == 32'h5555AAAA, "R6 write keeps data reg", v, 32'h5555AAAA);

        // R8 stall on data read
        rsp_dly = 6;
        host_wr(2'd1, 32'h00ABCD00);
        host_wr(2'd0, cmd_of(8'h10, 8'h09, 8'h44, 4'hF));
        host_rd(2'd3, v, st);
        check(v == 1, "R10 status busy", v, 1);
        host_rd(2'd2, v, st);
        check(st > 0, "R8 stalled", st, 1);
        check(v == resp_of(32'h00ABCD44, 8'h09), "R8 stalled read value", v,
              resp_of(32'h00ABCD44, 8'h09));
        check(busy === 0, "R7 idle after response", {31'b0, busy}, 0);

        // R9 control write while busy
        n0 = n_req;
        host_wr(2'd2, 32'h0F0F0F0F);
        host_wr(2'd0, cmd_of(8'h11, 8'h02, 8'h10, 4'hF));
        host_wr(2'd0, cmd_of(8'h10, 8'h03, 8'h20, 4'hF));
        check(err === 1, "R9 err set", {31'b0, err}, 1);
        wait_idle();
        repeat (3) @(negedge clk);
        check(n_req == n0 + 1, "R9 no second request", n_req, n0 + 1);
        check(cap_port == 8'h02, "R9 first request kept", cap_port, 8'h02);
        host_rd(2'd0, v, st);
        check(v == cmd_of(8'h11, 8'h02, 8'h10, 4'hF), "R9 ctrl unchanged", v,
              cmd_of(8'h11, 8'h02, 8'h10, 4'hF));
        host_rd(2'd3, v, st);
        check(v == 2, "R10 status err", v, 2);

        // random mix
        for (int i = 0; i < 40; i++) begin
            logic [7:0] op;
            logic [31:0] a;
            int k;
            k = $urandom % 4;
            op = (k == 0) ? 8'h10 : (k == 1) ? 8'h11 : (k == 2) ? 8'hE0 : 8'($urandom);
            a = ($urandom % 2) ? $urandom : {24'h0, 8'($urandom)};
            rsp_dly = $urandom % 5;
            do_txn(op, 8'($urandom), a, 4'($urandom), $urandom);
        end
        check(err === 1, "R9 err sticky", {31'b0, err}, 1);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule